// File: doc/BRIEF.md
# Clear-on-Compare Timer with Two Compare Channels

This block is a 16-bit up-counting timer with two compare registers. A small register write port loads compare value A, compare value B and a control word that selects the clock divider, turns the clear-on-compare behaviour on or off, and enables an interrupt per channel. The counter moves only on ticks from the divider. When clear-on-compare is on, compare A is the last count of each cycle, and the counter returns to zero on the next tick. Compare B does not change the cycle length. It only marks a point inside each cycle.

Each channel has a sticky match flag. The flag is set on the tick where the counter equals that channel's compare value, and an acknowledge pulse clears it. The interrupt line of a channel is high while its flag and its enable bit are both set. Software sets the period with A and a phase point with B. So the rate of B events follows A alone, and moving B only shifts when in the cycle the event falls.

Top module: `ctc_dual_timer`

## Requirements
- R1: After reset, count is 0, both flags and both interrupt outputs are 0, both compare values are 0 and the control word is 0, so the counter is stopped.
- R2: Control bits [2:0] select the divider: 0 stops the counter, 1/2/3/4/5 advance it once every 1/8/64/256/1024 clock cycles, and 6 and 7 also stop it. Between ticks the count holds.
- R3: With control bit 3 set (clear-on-compare), a tick at count equal to compare A takes the count to 0. Any other tick adds one.
- R4: With control bit 3 clear, the counter runs through 0xFFFF back to 0 and ignores compare A for its period. Both channels still set their flags on equality.
- R5: A channel's flag is set in the cycle after a tick on which the count equals that channel's compare value (channel A at write address 0, channel B at address 1).
- R6: In clear-on-compare mode with B not above A, flag B is set once per A+1 ticks. The rate does not depend on B, and halving A+1 doubles the rate.
- R7: In clear-on-compare mode with the count starting at 0 and B above A, flag B is never set.
- R8: A flag stays set until an acknowledge pulse (ack_a, ack_b). If a match and an acknowledge fall on the same tick, the flag stays set.
- R9: irq_a is high exactly when flag A and control bit 4 are both set. irq_b is high exactly when flag B and control bit 5 are both set. Both may be enabled together.
- R10: Writes use address 0 for compare A, 1 for compare B and 2 for the control word. A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 16 | Write data (control uses bits [5:0]) |
| ack_a | input | 1 | Clears flag A |
| ack_b | input | 1 | Clears flag B |
| count | output | 16 | Current counter value |
| flag_a | output | 1 | Sticky compare-A match flag |
| flag_b | output | 1 | Sticky compare-B match flag |
| irq_a | output | 1 | Flag A gated by its enable |
| irq_b | output | 1 | Flag B gated by its enable |

## Verification
The bench counts B events over fixed windows. It checks that moving B keeps the same count of events and that shrinking A doubles it. A design that tied the cycle length to B, or restarted the count at B, would show a changed event count. With B placed above A, the bench expects no event at all, which catches a design that compares with greater-or-equal. Holding the acknowledge high while matches arrive checks that a match beats a clear on the same tick: if the acknowledge won, no event would ever be seen. A run through the full 16-bit range in normal mode checks that the counter wraps and is not cut short at A.

// File: rtl/ctc_timer_pkg.sv
package ctc_timer_pkg;
  localparam int CNT_W   = 16;
  localparam int CSEL_W  = 3;
  localparam int PRE_W   = 11;
  localparam int ADDR_W  = 2;
  localparam int NCH     = 2;
  localparam int CTRL_W  = CSEL_W + 1 + NCH;
  localparam int BIT_CTC = CSEL_W;
  localparam int BIT_EN0 = CSEL_W + 1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(NCH);

  // Divider length for a clock-select code; 0 means no ticks.
  function automatic logic [PRE_W-1:0] prescale_div(input logic [CSEL_W-1:0] sel);
    case (sel)
      3'd1:    return PRE_W'(1);
      3'd2:    return PRE_W'(1) << 3;
      3'd3:    return PRE_W'(1) << 6;
      3'd4:    return PRE_W'(1) << 8;
      3'd5:    return PRE_W'(1) << 10;
      default: return '0;
    endcase
  endfunction

  // Count value after one tick.
  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cur,
                                                  input logic [CNT_W-1:0] top,
                                                  input logic ctc);
    if (ctc && (cur == top)) return '0;
    return cur + 1'b1;
  endfunction
endpackage

// File: rtl/ctc_prescaler.sv
module ctc_prescaler
  import ctc_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CSEL_W-1:0] sel,
  output logic              tick
);
  logic [PRE_W-1:0] div_len;
  logic [PRE_W-1:0] pre_q;

  assign div_len = prescale_div(sel);
  assign tick    = (div_len != '0) && (pre_q >= div_len - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          pre_q <= '0;
    else if ((div_len == '0) || tick)    pre_q <= '0;
    else                                 pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/ctc_counter.sv
module ctc_counter
  import ctc_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ctc,
  input  logic [CNT_W-1:0] top,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (tick) count <= next_count(count, top, ctc);
  end
endmodule

// File: rtl/ctc_match_flag.sv
module ctc_match_flag
  import ctc_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] ref_val,
  input  logic             ack,
  output logic             match,
  output logic             flag
);
  assign match = tick && (count == ref_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag <= 1'b0;
    else if (match) flag <= 1'b1;
    else if (ack)   flag <= 1'b0;
  end
endmodule

// File: rtl/ctc_dual_timer.sv
module ctc_dual_timer
  import ctc_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              ack_a,
  input  logic              ack_b,
  output logic [CNT_W-1:0]  count,
  output logic              flag_a,
  output logic              flag_b,
  output logic              irq_a,
  output logic              irq_b
);
  logic [NCH-1:0][CNT_W-1:0] cmp_q;
  logic [CTRL_W-1:0]         ctrl_q;
  logic [NCH-1:0]            ack_v, match_v, flag_v, en_v;
  logic                      tick;

  // Named internal events for the checker.
  logic [CNT_W-1:0] cmp_a, cmp_b;
  logic             ctc_on, match_a, match_b, en_a, en_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      ctrl_q <= '0;
    end else if (wr_en) begin
      for (int ch = 0; ch < NCH; ch++)
        if (wr_addr == ADDR_W'(ch)) cmp_q[ch] <= wr_data;
      if (wr_addr == ADDR_CTRL) ctrl_q <= wr_data[CTRL_W-1:0];
    end
  end

  assign ctc_on = ctrl_q[BIT_CTC];
  assign en_v   = ctrl_q[BIT_EN0 +: NCH];
  assign ack_v  = {ack_b, ack_a};

  ctc_prescaler u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .sel  (ctrl_q[CSEL_W-1:0]),
    .tick (tick)
  );

  ctc_counter u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick),
    .ctc  (ctc_on),
    .top  (cmp_q[0]),
    .count(count)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    ctc_match_flag u_cmp (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .count  (count),
      .ref_val(cmp_q[ch]),
      .ack    (ack_v[ch]),
      .match  (match_v[ch]),
      .flag   (flag_v[ch])
    );
  end

  assign cmp_a   = cmp_q[0];
  assign cmp_b   = cmp_q[1];
  assign match_a = match_v[0];
  assign match_b = match_v[1];
  assign en_a    = en_v[0];
  assign en_b    = en_v[1];
  assign flag_a  = flag_v[0];
  assign flag_b  = flag_v[1];
  assign irq_a   = flag_v[0] & en_v[0];
  assign irq_b   = flag_v[1] & en_v[1];
endmodule

// File: rtl/ctc_dual_timer_checker.sv
module ctc_dual_timer_checker
  import ctc_timer_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             ctc_on,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] cmp_a,
  input logic             match_a,
  input logic             match_b,
  input logic             flag_a,
  input logic             flag_b,
  input logic             ack_a,
  input logic             ack_b,
  input logic             en_a,
  input logic             en_b,
  input logic             irq_a,
  input logic             irq_b
);
  assert_hold_between_ticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));

  assert_ctc_return_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctc_on && tick && count == cmp_a) |=> (count == '0));

  assert_ctc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctc_on && tick && count != cmp_a) |=> (count == $past(count) + 1'b1));

  assert_normal_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctc_on && tick && count == '1) |=> (count == '0));

  assert_match_sets_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
    match_a |=> flag_a);

  assert_match_sets_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
    match_b |=> flag_b);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_a && !ack_a) |=> flag_a);

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_b && !match_b) |=> !flag_b);

  assert_irq_gate_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_a |-> (flag_a && en_a));

  assert_irq_gate_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_b && en_b) |-> irq_b);
endmodule

bind ctc_dual_timer ctc_dual_timer_checker u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .tick   (tick),
  .ctc_on (ctc_on),
  .count  (count),
  .cmp_a  (cmp_a),
  .match_a(match_a),
  .match_b(match_b),
  .flag_a (flag_a),
  .flag_b (flag_b),
  .ack_a  (ack_a),
  .ack_b  (ack_b),
  .en_a   (en_a),
  .en_b   (en_b),
  .irq_a  (irq_a),
  .irq_b  (irq_b)
);

// File: tb/ctc_dual_timer_tb.sv
`timescale 1ns/1ps
module ctc_dual_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        ack_a = 1'b0, ack_b = 1'b0;
  logic [15:0] count;
  logic        flag_a, flag_b, irq_a, irq_b;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ctc_dual_timer u_dut (.*);

  // Behavioural reference model, advanced on every rising edge.
  int m_pre = 0, m_cnt = 0, m_A = 0, m_B = 0, m_ctrl = 0;
  bit m_fa = 0, m_fb = 0;

  function automatic int ref_div(input int sel);
    int tbl[8] = '{0, 1, 8, 64, 256, 1024, 0, 0};
    return tbl[sel];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = 0; m_cnt = 0; m_A = 0; m_B = 0; m_ctrl = 0; m_fa = 0; m_fb = 0;
    end else begin
      int d;
      bit t, ma, mb;
      d  = ref_div(m_ctrl % 8);
      t  = (d > 0) && (m_pre + 1 >= d);
      m_pre = t ? 0 : ((d == 0) ? 0 : m_pre + 1);
      ma = t && (m_cnt == m_A);
      mb = t && (m_cnt == m_B);
      if (t) begin
        if (((m_ctrl / 8) % 2 == 1) && m_cnt == m_A) m_cnt = 0;
        else m_cnt = (m_cnt + 1) % 65536;
      end
      if (ma) m_fa = 1; else if (ack_a) m_fa = 0;
      if (mb) m_fb = 1; else if (ack_b) m_fb = 0;
      if (wr_en) begin
        if (wr_addr == 2'd0) m_A = wr_data;
        if (wr_addr == 2'd1) m_B = wr_data;
        if (wr_addr == 2'd2) m_ctrl = wr_data % 64;
      end
    end
  end

  // Cycle compare against the model (R2 R3 R4 R5 R8 R9).
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit ia, ib;
      ia = m_fa && ((m_ctrl / 16) % 2 == 1);
      ib = m_fb && ((m_ctrl / 32) % 2 == 1);
      checks++;
      if (count != 16'(m_cnt) || flag_a != m_fa || flag_b != m_fb || irq_a != ia || irq_b != ib) begin
        fails++;
        $display("FAIL R2/R3/R4/R5/R8/R9 model: count=%0d flags=%b%b irqs=%b%b expected count=%0d flags=%b%b irqs=%b%b",
                 count, flag_a, flag_b, irq_a, irq_b, m_cnt, m_fa, m_fb, ia, ib);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic count_events(input int n, output int ea, output int eb);
    ea = 0; eb = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (flag_a) ea++;
      if (flag_b) eb++;
    end
  endtask

  // Control word: bits[2:0] divider, bit3 clear-on-compare, bit4 en A, bit5 en B.
  localparam logic [15:0] CTL_RUN = 16'h0039;

  initial begin
    int ea, eb;
    ack_a = 1'b1; ack_b = 1'b1;
    do_reset();
    @(negedge clk);
    check(count == 0 && !flag_a && !flag_b && !irq_a && !irq_b, "R1 reset state", count, 0);
    repeat (20) @(negedge clk);
    check(count == 0, "R2 stopped with divider code 0", count, 0);

    wr(2'd0, 16'd9); wr(2'd1, 16'd3); wr(2'd2, CTL_RUN);
    count_events(200, ea, eb);
    check(eb == 20, "R6 B=3 A=9 events", eb, 20);
    check(ea == 20, "R3 A events per cycle", ea, 20);
    wr(2'd1, 16'd7);
    count_events(200, ea, eb);
    check(eb == 20, "R6 B moved, rate unchanged", eb, 20);
    wr(2'd3, 16'd0);
    count_events(200, ea, eb);
    check(eb == 20 && ea == 20, "R10 address 3 ignored", eb, 20);

    do_reset();
    wr(2'd0, 16'd4); wr(2'd1, 16'd2); wr(2'd2, CTL_RUN);
    count_events(200, ea, eb);
    check(eb == 40, "R6 halved period doubles rate", eb, 40);

    do_reset();
    wr(2'd0, 16'd4); wr(2'd1, 16'd8); wr(2'd2, CTL_RUN);
    count_events(200, ea, eb);
    check(eb == 0, "R7 B above A never matches", eb, 0);
    check(ea == 40, "R3 A still matches", ea, 40);

    do_reset();
    wr(2'd0, 16'd3); wr(2'd1, 16'd0); wr(2'd2, 16'h003A);
    count_events(320, ea, eb);
    check(eb == 10, "R2 divide by 8", eb, 10);
    wr(2'd2, 16'h003E);
    begin
      logic [15:0] c0;
      @(negedge clk); c0 = count;
      repeat (40) @(negedge clk);
      check(count == c0, "R2 code 6 stops", count, c0);
    end

    do_reset();
    wr(2'd0, 16'd5); wr(2'd1, 16'd9); wr(2'd2, 16'h0031);
    repeat (20) @(negedge clk);
    check(count > 16'd5, "R4 normal mode passes A", count, 6);
    count_events(65536, ea, eb);
    check(ea == 1 && eb == 1, "R4 wrap gives one match each", ea, 1);

    do_reset();
    ack_a = 1'b0; ack_b = 1'b0;
    wr(2'd0, 16'd9); wr(2'd1, 16'd3); wr(2'd2, 16'h0019);
    repeat (6) @(negedge clk);
    check(flag_b == 1'b1, "R5 flag B set", flag_b, 1);
    check(irq_b == 1'b0, "R9 irq B masked", irq_b, 0);
    check(irq_a == flag_a, "R9 irq A follows flag", irq_a, flag_a);
    repeat (12) @(negedge clk);
    check(flag_b == 1'b1 && flag_a == 1'b1, "R8 flags sticky", flag_b, 1);
    while (count == 16'd3) @(negedge clk);
    ack_b = 1'b1;
    @(negedge clk); ack_b = 1'b0;
    check(flag_b == 1'b0 || count == 16'd4, "R8 ack clears", flag_b, 0);

    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule